// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Disparity Override

This block turns one byte, together with a flag that marks it as a control character, into a ten-bit DC-balanced transmission code. It keeps a running disparity, so every code it emits has a weight of four, five or six ones, and the choice between the two complementary forms of a code steers the line back towards balance. Control characters outside the accepted set are replaced by the comma character and flagged. One reserved byte value in control mode emits a fixed, deliberately illegal neutral codeword that a receiver will reject. When the transmitter is idle, a comma character can be inserted on request.

An external disparity input, gated by a force strobe, can replace the internal running disparity at the final stage. A combinational cascade output gives the disparity that the current word leaves behind. With these two ports, two instances encode a 16-bit word in one cycle. The upper instance takes its starting disparity from the lower instance's registered disparity. The lower instance takes its starting disparity from the upper instance's cascade output. Both force strobes are tied high. A parameter selects either a single output register or a three-register pipeline on the data path.

Top module: `enc8b10b`

## Requirements
- R1: Data bytes (control flag low) are encoded with the standard 5b/6b and 3b/4b code groups. Input bit 0 is the first data bit. Output bit 0 is the first transmitted bit. Output bits 0 to 5 hold the six-bit group (first six line bits) and bits 6 to 9 hold the four-bit group. After two comma characters from reset, byte 0x00 gives code 0x0B9.
- R2: Every emitted code has four, five or six ones. A code with six ones is emitted only from negative disparity and leaves it positive. A code with four ones is emitted only from positive disparity and leaves it negative. A code with five ones leaves the disparity unchanged. rd_out is 1 for positive.
- R3: With the control flag high, the twelve control bytes 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xBC, 0xDC, 0xFC, 0xF7, 0xFB, 0xFD and 0xFE are encoded as their standard control codes. Each such code from positive disparity is the bitwise complement of its form from negative disparity.
- R4: Any other byte with the control flag and enable high, except 0xFF, raises ctrl_err in the same output cycle and emits the comma 0xBC. The comma's bus value is 0x17C from negative disparity and 0x283 from positive.
- R5: Byte 0xFF with the control flag high emits line bits 0011110001 from negative disparity and 1100001110 from positive disparity. It never raises ctrl_err and leaves the disparity unchanged.
- R6: With enable low and idle_req high, the block emits the comma at the current disparity with code_valid high and ctrl_err low.
- R7: When disp_force is high at the output edge, disp_ext replaces the internal disparity (0 = negative, 1 = positive) for the word registered at that edge.
- R8: cascade_rd equals, combinationally, the disparity after the word currently at the final stage, including forcing. The bench checks this with two cascaded instances that encode a 16-bit stream.
- R9: With THREE_STAGE = 0, inputs sampled at an edge appear at the outputs after that edge. With THREE_STAGE = 1, data, control flag, enable and idle sampled at edge n appear after edge n+2. The force inputs act only at the last edge.
- R10: Reset makes the disparity negative and clears code_valid and ctrl_err.
- R11: With enable and idle_req both low, code_valid is low, ctrl_err is low and the disparity changes only through forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Encode the presented byte |
| ctrl_k | input | 1 | Byte is a control character |
| idle_req | input | 1 | Insert a comma when enable is low |
| data_in | input | 8 | Byte to encode, bit 0 sent first |
| disp_ext | input | 1 | External starting disparity, 1 = positive |
| disp_force | input | 1 | Use disp_ext instead of the internal disparity |
| code_out | output | 10 | Ten-bit code, bit 0 transmitted first |
| ctrl_err | output | 1 | Unsupported control byte was replaced |
| code_valid | output | 1 | code_out holds a newly emitted code |
| rd_out | output | 1 | Running disparity after the registered word |
| cascade_rd | output | 1 | Combinational disparity after the final-stage word |

## Verification
The assertions assume that disp_force and disp_ext are held low during reset. They also assume that every force and external-disparity value is presented before the edge that uses it, and not changed at the edge itself. Stimulus is applied half a period away from the rising edge, and the force strobe stays low throughout reset. In the cascaded pair, the only external disparity presented to each instance is the partner's own output, so the chain is always consistent.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

    localparam int BYTE_W  = 8;
    localparam int CODE_W  = 10;
    localparam int SIX_W   = 6;
    localparam int FOUR_W  = 4;
    localparam int LOW_W   = 5;
    localparam int HIGH_W  = BYTE_W - LOW_W;

    localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;
    localparam logic [BYTE_W-1:0] POISON_BYTE = 8'hFF;
    localparam logic [LOW_W-1:0]  K28_LOW    = 5'd28;

    // Line order (first bit in MSB) of the poison codewords
    localparam logic [CODE_W-1:0] POISON_NEG = 10'b0011110001;
    localparam logic [CODE_W-1:0] POISON_POS = 10'b1100001110;

    typedef struct packed {
        logic              en;
        logic              k;
        logic              idle;
        logic [BYTE_W-1:0] dat;
    } enc_req_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              err;
        logic              vld;
        logic              rd;
    } enc_out_t;

    // Line order (first bit in MSB) to bus order (first bit in bit 0)
    function automatic logic [CODE_W-1:0] line_to_bus(input logic [CODE_W-1:0] line);
        logic [CODE_W-1:0] b;
        for (int i = 0; i < CODE_W; i++) b[i] = line[CODE_W-1-i];
        return b;
    endfunction

endpackage

// File: rtl/enc_kclass.sv
module enc_kclass
    import enc8b10b_pkg::*;
(
    input  logic [BYTE_W-1:0] dat,
    output logic              k_legal,
    output logic              k_poison
);
    logic [HIGH_W-1:0] hi;
    logic [LOW_W-1:0]  lo;

    assign hi = dat[BYTE_W-1:LOW_W];
    assign lo = dat[LOW_W-1:0];

    always_comb begin
        k_poison = (dat == POISON_BYTE);
        k_legal  = (lo == K28_LOW) ||
                   ((hi == 3'd7) && (lo == 5'd23 || lo == 5'd27 ||
                                     lo == 5'd29 || lo == 5'd30));
    end
endmodule

// File: rtl/enc_sixb.sv
module enc_sixb
    import enc8b10b_pkg::*;
(
    input  logic [LOW_W-1:0] x,
    input  logic             k28,
    input  logic             rd_in,
    output logic [SIX_W-1:0] grp,
    output logic             rd_mid
);
    logic [SIX_W-1:0] neg_form;
    logic [SIX_W-1:0] sel;
    logic             unbal;

    always_comb begin
        // first line bit in MSB, form used from negative disparity
        case (x)
            5'd0:  neg_form = 6'b100111;
            5'd1:  neg_form = 6'b011101;
            5'd2:  neg_form = 6'b101101;
            5'd3:  neg_form = 6'b110001;
            5'd4:  neg_form = 6'b110101;
            5'd5:  neg_form = 6'b101001;
            5'd6:  neg_form = 6'b011001;
            5'd7:  neg_form = 6'b111000;
            5'd8:  neg_form = 6'b111001;
            5'd9:  neg_form = 6'b100101;
            5'd10: neg_form = 6'b010101;
            5'd11: neg_form = 6'b110100;
            5'd12: neg_form = 6'b001101;
            5'd13: neg_form = 6'b101100;
            5'd14: neg_form = 6'b011100;
            5'd15: neg_form = 6'b010111;
            5'd16: neg_form = 6'b011011;
            5'd17: neg_form = 6'b100011;
            5'd18: neg_form = 6'b010011;
            5'd19: neg_form = 6'b110010;
            5'd20: neg_form = 6'b001011;
            5'd21: neg_form = 6'b101010;
            5'd22: neg_form = 6'b011010;
            5'd23: neg_form = 6'b111010;
            5'd24: neg_form = 6'b110011;
            5'd25: neg_form = 6'b100110;
            5'd26: neg_form = 6'b010110;
            5'd27: neg_form = 6'b110110;
            5'd28: neg_form = 6'b001110;
            5'd29: neg_form = 6'b101110;
            5'd30: neg_form = 6'b011110;
            default: neg_form = 6'b101011;
        endcase
        if (k28) neg_form = 6'b001111;
        unbal  = ($countones(neg_form) != 3);
        sel    = (rd_in && (unbal || x == 5'd7)) ? ~neg_form : neg_form;
        rd_mid = rd_in ^ unbal;
        for (int i = 0; i < SIX_W; i++) grp[i] = sel[SIX_W-1-i];
    end
endmodule

// File: rtl/enc_fourb.sv
module enc_fourb
    import enc8b10b_pkg::*;
(
    input  logic [HIGH_W-1:0] y,
    input  logic [LOW_W-1:0]  x,
    input  logic              kmode,
    input  logic              k28,
    input  logic              rd_mid,
    output logic [FOUR_W-1:0] grp,
    output logic              rd_end
);
    logic [FOUR_W-1:0] base;
    logic [FOUR_W-1:0] sel;
    logic              use_alt;
    logic              unbal;
    logic              flip;

    always_comb begin
        use_alt = kmode ||
                  (!rd_mid && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
                  ( rd_mid && (x == 5'd11 || x == 5'd13 || x == 5'd14));
        case (y)
            3'd0: base = 4'b1011;
            3'd1: base = 4'b1001;
            3'd2: base = 4'b0101;
            3'd3: base = 4'b1100;
            3'd4: base = 4'b1101;
            3'd5: base = 4'b1010;
            3'd6: base = 4'b0110;
            default: base = use_alt ? 4'b0111 : 4'b1110;
        endcase
        unbal = ($countones(base) != 2);
        flip  = rd_mid && (unbal || y == 3'd3 || y == 3'd7);
        // comma-family neutral groups invert after a negative six-bit group
        if (k28 && !rd_mid && (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6))
            flip = 1'b1;
        sel    = flip ? ~base : base;
        rd_end = rd_mid ^ unbal;
        for (int i = 0; i < FOUR_W; i++) grp[i] = sel[FOUR_W-1-i];
    end
endmodule

// File: rtl/enc8b10b.sv
module enc8b10b
    import enc8b10b_pkg::*;
#(
    parameter bit THREE_STAGE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ctrl_k,
    input  logic              idle_req,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              disp_ext,
    input  logic              disp_force,
    output logic [CODE_W-1:0] code_out,
    output logic              ctrl_err,
    output logic              code_valid,
    output logic              rd_out,
    output logic              cascade_rd
);
    localparam int PIPE_REGS = THREE_STAGE ? 2 : 0;

    enc_req_t cur;
    enc_req_t fin;
    enc_out_t out_d, out_q;

    assign cur = '{en: enable, k: ctrl_k, idle: idle_req, dat: data_in};

    generate
        if (PIPE_REGS > 0) begin : g_pipe
            enc_req_t pipe_q [PIPE_REGS];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < PIPE_REGS; i++) pipe_q[i] <= '0;
                end else begin
                    pipe_q[0] <= cur;
                    for (int i = 1; i < PIPE_REGS; i++) pipe_q[i] <= pipe_q[i-1];
                end
            end
            assign fin = pipe_q[PIPE_REGS-1];
        end else begin : g_direct
            assign fin = cur;
        end
    endgenerate

    logic              k_legal, k_poison;
    logic              k_on, bad_k, poison, emit, swap;
    logic [BYTE_W-1:0] eff_dat;
    logic              eff_k, eff_k28, rd_use, rd_mid, rd_end;
    logic [SIX_W-1:0]  g6;
    logic [FOUR_W-1:0] g4;

    enc_kclass u_kclass (.dat(fin.dat), .k_legal(k_legal), .k_poison(k_poison));

    always_comb begin
        k_on    = fin.en && fin.k;
        poison  = k_on && k_poison;
        bad_k   = k_on && !k_legal && !k_poison;
        emit    = fin.en || fin.idle;
        swap    = (!fin.en && fin.idle) || bad_k;
        eff_dat = swap ? COMMA_BYTE : fin.dat;
        eff_k   = swap || k_on;
        eff_k28 = eff_k && (eff_dat[LOW_W-1:0] == K28_LOW);
        rd_use  = disp_force ? disp_ext : out_q.rd;
    end

    enc_sixb u_sixb (
        .x(eff_dat[LOW_W-1:0]), .k28(eff_k28), .rd_in(rd_use),
        .grp(g6), .rd_mid(rd_mid)
    );

    enc_fourb u_fourb (
        .y(eff_dat[BYTE_W-1:LOW_W]), .x(eff_dat[LOW_W-1:0]), .kmode(eff_k),
        .k28(eff_k28), .rd_mid(rd_mid), .grp(g4), .rd_end(rd_end)
    );

    always_comb begin
        out_d     = out_q;
        out_d.err = 1'b0;
        out_d.vld = emit;
        out_d.rd  = rd_use;
        if (poison) begin
            out_d.code = line_to_bus(rd_use ? POISON_POS : POISON_NEG);
        end else if (emit) begin
            out_d.code = {g4, g6};
            out_d.rd   = rd_end;
            out_d.err  = bad_k;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign code_out   = out_q.code;
    assign ctrl_err   = out_q.err;
    assign code_valid = out_q.vld;
    assign rd_out     = out_q.rd;
    assign cascade_rd = out_d.rd;
endmodule

// File: rtl/enc8b10b_chk.sv
module enc8b10b_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       disp_force,
    input logic       disp_ext,
    input logic [9:0] code_out,
    input logic       code_valid,
    input logic       ctrl_err,
    input logic       rd_out
);
    // R2: emitted weight stays within one step of balance
    a_r2_weight: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> ($countones(code_out) inside {4, 5, 6}));

    // R2: heavy code only from negative, leaves positive
    a_r2_heavy: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $countones(code_out) == 6) |->
            (rd_out && !$past(disp_force ? disp_ext : rd_out)));

    // R2: light code only from positive, leaves negative
    a_r2_light: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && $countones(code_out) == 4) |->
            (!rd_out && $past(disp_force ? disp_ext : rd_out)));

    // R11 / R7: without a weighted code, disparity only moves by forcing
    a_r11_rd_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_valid || $countones(code_out) == 5) |->
            (rd_out == $past(disp_force ? disp_ext : rd_out)));

    // R4: error flag comes with a comma code
    a_r4_err_comma: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err |-> (code_valid && (code_out == 10'h17C || code_out == 10'h283)));
endmodule

bind enc8b10b enc8b10b_chk u_chk (
    .clk(clk), .rst_n(rst_n), .disp_force(disp_force), .disp_ext(disp_ext),
    .code_out(code_out), .code_valid(code_valid), .ctrl_err(ctrl_err), .rd_out(rd_out)
);

// File: tb/enc8b10b_bench.sv
`timescale 1ns/1ps
module enc8b10b_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, kf = 1'b0, idle = 1'b0, dext = 1'b0, dforce = 1'b0;
    logic [7:0] dat = 8'h00;
    logic [7:0] dat_lo;

    logic [9:0] c1, c3, chi, clo;
    logic e1, v1, r1, cas1, e3, v3, r3, cas3;
    logic ehi, vhi, rhi, cashi, elo, vlo, rlo, caslo;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    assign dat_lo = dat ^ 8'h5A;

    enc8b10b #(.THREE_STAGE(1'b0)) u_enc8b10b (
        .clk(clk), .rst_n(rst_n), .enable(en), .ctrl_k(kf), .idle_req(idle),
        .data_in(dat), .disp_ext(dext), .disp_force(dforce),
        .code_out(c1), .ctrl_err(e1), .code_valid(v1), .rd_out(r1), .cascade_rd(cas1));

    enc8b10b #(.THREE_STAGE(1'b1)) u_enc8b10b_lat3 (
        .clk(clk), .rst_n(rst_n), .enable(en), .ctrl_k(kf), .idle_req(idle),
        .data_in(dat), .disp_ext(dext), .disp_force(dforce),
        .code_out(c3), .ctrl_err(e3), .code_valid(v3), .rd_out(r3), .cascade_rd(cas3));

    enc8b10b u_cas_hi (
        .clk(clk), .rst_n(rst_n), .enable(en), .ctrl_k(kf), .idle_req(idle),
        .data_in(dat), .disp_ext(rlo), .disp_force(rst_n),
        .code_out(chi), .ctrl_err(ehi), .code_valid(vhi), .rd_out(rhi), .cascade_rd(cashi));

    enc8b10b u_cas_lo (
        .clk(clk), .rst_n(rst_n), .enable(en), .ctrl_k(kf), .idle_req(idle),
        .data_in(dat_lo), .disp_ext(cashi), .disp_force(rst_n),
        .code_out(clo), .ctrl_err(elo), .code_valid(vlo), .rd_out(rlo), .cascade_rd(caslo));

    // ---------------- reference model ----------------
    function automatic logic [9:0] rev10(input logic [9:0] t);
        logic [9:0] b;
        for (int i = 0; i < 10; i++) b[i] = t[9-i];
        return b;
    endfunction

    function automatic bit is_ctrl(input logic [7:0] b);
        return b inside {8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC, 8'hDC, 8'hFC,
                         8'hF7, 8'hFB, 8'hFD, 8'hFE};
    endfunction

    function automatic logic [7:0] ctrl_pick(input int idx);
        case (idx)
            0: return 8'h1C;  1: return 8'h3C;  2: return 8'h5C;  3: return 8'h7C;
            4: return 8'h9C;  5: return 8'hBC;  6: return 8'hDC;  7: return 8'hFC;
            8: return 8'hF7;  9: return 8'hFB; 10: return 8'hFD; 11: return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    // whole control words in line order, negative-disparity form
    function automatic logic [9:0] ctrl_word(input logic [7:0] b);
        case (b)
            8'h1C: return 10'b0011110100;
            8'h3C: return 10'b0011111001;
            8'h5C: return 10'b0011110101;
            8'h7C: return 10'b0011110011;
            8'h9C: return 10'b0011110010;
            8'hBC: return 10'b0011111010;
            8'hDC: return 10'b0011110110;
            8'hFC: return 10'b0011111000;
            8'hF7: return 10'b1110101000;
            8'hFB: return 10'b1101101000;
            8'hFD: return 10'b1011101000;
            default: return 10'b0111101000;
        endcase
    endfunction

    function automatic logic [10:0] ref_data(input logic [7:0] b, input logic rd);
        logic [5:0] s; logic [3:0] f; logic r; int x, y;
        x = b[4:0]; y = b[7:5]; r = rd;
        case (x)
            0: s = 6'b100111;  1: s = 6'b011101;  2: s = 6'b101101;  3: s = 6'b110001;
            4: s = 6'b110101;  5: s = 6'b101001;  6: s = 6'b011001;  7: s = 6'b111000;
            8: s = 6'b111001;  9: s = 6'b100101; 10: s = 6'b010101; 11: s = 6'b110100;
           12: s = 6'b001101; 13: s = 6'b101100; 14: s = 6'b011100; 15: s = 6'b010111;
           16: s = 6'b011011; 17: s = 6'b100011; 18: s = 6'b010011; 19: s = 6'b110010;
           20: s = 6'b001011; 21: s = 6'b101010; 22: s = 6'b011010; 23: s = 6'b111010;
           24: s = 6'b110011; 25: s = 6'b100110; 26: s = 6'b010110; 27: s = 6'b110110;
           28: s = 6'b001110; 29: s = 6'b101110; 30: s = 6'b011110; default: s = 6'b101011;
        endcase
        if ($countones(s) != 3) begin if (r) s = ~s; r = ~r; end
        else if (x == 7 && r) s = ~s;
        case (y)
            0: f = 4'b1011; 1: f = 4'b1001; 2: f = 4'b0101; 3: f = 4'b1100;
            4: f = 4'b1101; 5: f = 4'b1010; 6: f = 4'b0110;
            default: f = ((!r && (x == 17 || x == 18 || x == 20)) ||
                          ( r && (x == 11 || x == 13 || x == 14))) ? 4'b0111 : 4'b1110;
        endcase
        if ($countones(f) != 2) begin if (r) f = ~f; r = ~r; end
        else if (y == 3 && r) f = ~f;
        return {r, rev10({s, f})};
    endfunction

    // one word: returns expected valid, error, bus code, disparity after, tag
    task automatic model(input logic e, k, i, input logic [7:0] b, input logic rd,
                         output logic vld, output logic err, output logic [9:0] code,
                         output logic rdn, output string tag);
        logic [9:0] w;
        vld = e || i; err = 1'b0; code = '0; rdn = rd; tag = "R11";
        if (!e && i) begin
            w = rd ? ~ctrl_word(8'hBC) : ctrl_word(8'hBC);
            code = rev10(w); rdn = ~rd; tag = "R6";
        end else if (e && k && b == 8'hFF) begin
            code = rev10(rd ? 10'b1100001110 : 10'b0011110001); tag = "R5";
        end else if (e && k) begin
            tag = is_ctrl(b) ? "R3" : "R4";
            err = !is_ctrl(b);
            w = ctrl_word(is_ctrl(b) ? b : 8'hBC);
            if (rd) w = ~w;
            code = rev10(w);
            rdn = ($countones(w) == 5) ? rd : ~rd;
        end else if (e) begin
            {rdn, code} = ref_data(b, rd); tag = "R1";
        end
    endtask

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic m1_rd = 1'b0, m3_rd = 1'b0, mc_rd = 1'b0;
    logic [10:0] p1 = '0, p2 = '0;  // {en,k,idle} and byte in flight (three-stage)

    task automatic cycle(input logic e, k, i, input logic [7:0] b, input logic f, x);
        logic v_a, er_a, rn_a, v_b, er_b, rn_b, v_h, er_h, rn_h, v_l, er_l, rn_l;
        logic [9:0] c_a, c_b, c_h, c_l;
        string t_a, t_b, t_h, t_l;
        en = e; kf = k; idle = i; dat = b; dforce = f; dext = x;
        model(e, k, i, b, f ? x : m1_rd, v_a, er_a, c_a, rn_a, t_a);
        model(p2[10], p2[9], p2[8], p2[7:0], f ? x : m3_rd, v_b, er_b, c_b, rn_b, t_b);
        model(e, k, i, b, mc_rd, v_h, er_h, c_h, rn_h, t_h);
        model(e, k, i, b ^ 8'h5A, rn_h, v_l, er_l, c_l, rn_l, t_l);
        #1;
        check("R8 cascade one-stage", {9'd0, cas1}, {9'd0, rn_a});
        check("R8 cascade three-stage", {9'd0, cas3}, {9'd0, rn_b});
        @(posedge clk); @(negedge clk);
        check({t_a, " valid"}, {9'd0, v1}, {9'd0, v_a});
        check("R4 error flag", {9'd0, e1}, {9'd0, er_a});
        check(f ? "R7 disparity" : "R2 disparity", {9'd0, r1}, {9'd0, rn_a});
        if (v_a) check({t_a, " code"}, c1, c_a);
        check("R9 three-stage valid", {9'd0, v3}, {9'd0, v_b});
        check("R9 three-stage error", {9'd0, e3}, {9'd0, er_b});
        check("R9 three-stage disparity", {9'd0, r3}, {9'd0, rn_b});
        if (v_b) check({"R9 three-stage ", t_b}, c3, c_b);
        if (v_h) check("R8 cascade upper code", chi, c_h);
        if (v_l) check("R8 cascade lower code", clo, c_l);
        check("R8 cascade disparity", {8'd0, rhi, rlo}, {8'd0, rn_h, rn_l});
        m1_rd = rn_a; m3_rd = rn_b; mc_rd = rn_l;
        p2 = p1; p1 = {e, k, i, b};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid", {9'd0, v1}, 10'd0);
        check("R10 reset error", {9'd0, e1}, 10'd0);
        check("R10 reset disparity", {9'd0, r1}, 10'd0);
        rst_n = 1'b1;
        // directed
        cycle(0, 0, 1, 8'h00, 0, 0); check("R6 comma from negative", c1, 10'h17C);
        cycle(0, 0, 1, 8'h00, 0, 0); check("R6 comma from positive", c1, 10'h283);
        cycle(1, 0, 0, 8'h00, 0, 0); check("R1 byte 0x00 bus value", c1, 10'h0B9);
        cycle(0, 0, 1, 8'h00, 1, 1); check("R7 forced positive comma", c1, 10'h283);
        check("R7 disparity after forced comma", {9'd0, r1}, 10'd0);
        cycle(1, 1, 0, 8'h55, 0, 0); check("R4 invalid control flagged", {9'd0, e1}, 10'd1);
        cycle(1, 1, 0, 8'hFF, 0, 0); check("R5 poison no error", {9'd0, e1}, 10'd0);
        cycle(0, 0, 0, 8'h3C, 0, 0); check("R11 quiet cycle", {9'd0, v1}, 10'd0);
        // sweeps
        for (int b = 0; b < 256; b++) cycle(1, 0, 0, b[7:0], 0, 0);
        for (int b = 0; b < 256; b++) cycle(1, 1, 0, b[7:0], 0, 0);
        for (int j = 0; j < 26; j++) cycle(1, 1, 0, ctrl_pick(j % 13), 0, 0);
        // mixed traffic
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            logic [7:0] b;
            r = $urandom;
            b = r[23:16];
            if (r[2] & r[3] & r[4]) b = ctrl_pick(int'(r[31:24]) % 13);
            cycle(r[0] | r[1], r[2] & r[3], r[5], b, r[7:6] == 2'b00, r[8]);
        end
        repeat (4) cycle(0, 0, 0, 8'h00, 0, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule